// File: doc/BRIEF.md
# Remote Byte-Masked Mailbox Writer

This unit takes 64-bit command writes from a local requester and turns each one into a 32-bit read-modify-write on another core's register space. Two command offsets are decoded. The mailbox command targets one of eight mailbox word slots at a fixed base. The free-address command targets any 16-bit address named in the command. Each command names a target core. A four-bit keep mask chooses which bytes of the existing target word survive. The remaining bytes are taken from the upper half of the command.

The unit drives a single-outstanding memory request channel toward the target side. Every request carries the index of the target core, so the access is made on that core's behalf. A request is held until it is granted, and read data arrives later with its own valid strobe. The command side is busy from acceptance until the single response pulse. That pulse reports success, or a decode error when the target core does not exist. Commands that miss both offsets, or that are not 64 bits wide, are dropped and get a success response.

Top module: `mbox_rmw_writer`

## Requirements
- R1: A command with `cmd_is64_i` low makes no memory request and gets a response with `rsp_err_o` = 0, even at a command offset.
- R2: Only 12-bit offsets `MAIL_OFF` (default 0x048) and `ANY_OFF` (default 0x158) are commands. Any other offset makes no memory request and gets a response with `rsp_err_o` = 0.
- R3: The target core ID is command bits [25:16]. An ID of `NUM_CORES` or above gets a response with `rsp_err_o` = 1 and makes no memory request.
- R4: For the mailbox command, the target address is `MBOX_BASE` + 0x20 + (command & 0x1C).
- R5: For the free-address command, the target address is command bits [15:0].
- R6: Command bit 27+i set keeps byte i (bits 8i+7..8i) of the old target word. A cleared bit takes that byte from command bits [63:32]. When any keep bit is set, exactly one read is issued, followed by one write.
- R7: When keep bits [30:27] are all zero, no read is issued and the full payload [63:32] is written in one write.
- R8: Every memory request carries the target core index on `mem_core_o`, so the read and the write touch only that core's space.
- R9: Each accepted command gets exactly one single-cycle `rsp_valid_o` pulse. `cmd_ready_o` is low from acceptance until after that pulse.
- R10: A memory request that is not granted stays asserted in the next cycle with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command write present |
| cmd_ready_o | output | 1 | Unit idle, command accepted when valid |
| cmd_is64_i | input | 1 | Write is a full 64-bit access |
| cmd_off_i | input | 12 | Low 12 bits of the write address |
| cmd_data_i | input | 64 | Command word |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_err_o | output | 1 | Decode error (unknown target), valid with rsp_valid_o |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Target byte address |
| mem_core_o | output | 2 | Target core index the access is made for |
| mem_wdata_o | output | 32 | Merged write data, little-endian bytes |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The hardest situation to reach is a read-modify-write whose request sits ungranted for several cycles. The old word must then be merged only after the delayed read data returns, with the keep mask still applied correctly. The bench drives grant randomly each cycle, so requests stall at both the read and the write phase. A memory model with a distinct word pattern per core and per address makes a wrong byte, address or core tag show up in the written word. Directed cases cover masks of all-keep, none-keep and mixed, unknown core IDs at the top of the 10-bit field, and narrow or off-offset writes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_READ,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned CMD_W      = 64;
endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode #(
  parameter int unsigned        NUM_CORES = 4,
  parameter int unsigned        IDX_W     = 2,
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [11:0]        MAIL_OFF  = 12'h048,
  parameter logic [11:0]        ANY_OFF   = 12'h158,
  parameter logic [ADDR_W-1:0]  MBOX_BASE = 16'h1000
) (
  input  logic [11:0]       off_i,
  input  logic              is64_i,
  input  logic [63:0]       data_i,
  output logic              hit_o,
  output logic              known_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        keep_o,
  output logic [31:0]       payload_o
);
  logic       is_mail, is_any;
  logic [9:0] core_id;
  logic       unused_bits;

  assign is_mail     = is64_i && (off_i == MAIL_OFF);
  assign is_any      = is64_i && (off_i == ANY_OFF);
  assign hit_o       = is_mail || is_any;
  assign core_id     = data_i[25:16];
  assign known_o     = 32'(core_id) < NUM_CORES;
  assign idx_o       = core_id[IDX_W-1:0];
  assign keep_o      = data_i[30:27];
  assign payload_o   = data_i[63:32];
  assign unused_bits = ^{data_i[31], data_i[26]};

  always_comb begin
    if (is_mail)
      addr_o = MBOX_BASE + ADDR_W'(32) + ADDR_W'({data_i[4:2], 2'b00});
    else
      addr_o = data_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/mbox_byte_merge.sv
module mbox_byte_merge #(
  parameter int unsigned BYTES = 4
) (
  input  logic [BYTES-1:0]   keep_i,
  input  logic [8*BYTES-1:0] old_i,
  input  logic [8*BYTES-1:0] new_i,
  output logic [8*BYTES-1:0] word_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign word_o[8*b +: 8] = keep_i[b] ? old_i[8*b +: 8] : new_i[8*b +: 8];
  end
endmodule

// File: rtl/mbox_rmw_seq.sv
module mbox_rmw_seq
  import mbox_pkg::*;
#(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hit_i,
  input  logic              known_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        keep_i,
  input  logic [31:0]       payload_i,
  output logic              idle_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  mem_core_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [3:0]        keep_o,
  output logic [31:0]       payload_o,
  output logic [31:0]       old_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [3:0]        keep_q;
  logic [31:0]       pay_q, old_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      keep_q  <= '0;
      pay_q   <= '0;
      old_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          err_q <= hit_i && !known_i;
          if (!hit_i || !known_i) begin
            state_q <= ST_DONE;
          end else begin
            addr_q  <= addr_i;
            idx_q   <= idx_i;
            keep_q  <= keep_i;
            pay_q   <= payload_i;
            old_q   <= '0;
            // no keep bits: skip the read entirely
            state_q <= (keep_i != 4'b0) ? ST_READ : ST_WRITE;
          end
        end
        ST_READ:      if (mem_gnt_i) state_q <= ST_WAIT_READ;
        ST_WAIT_READ: if (mem_rvalid_i) begin
          old_q   <= mem_rdata_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE:     if (mem_gnt_i) state_q <= ST_DONE;
        ST_DONE:      state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = state_q == ST_IDLE;
  assign rsp_valid_o = state_q == ST_DONE;
  assign rsp_err_o   = (state_q == ST_DONE) && err_q;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = state_q == ST_WRITE;
  assign mem_addr_o  = addr_q;
  assign mem_core_o  = idx_q;
  assign keep_o      = keep_q;
  assign payload_o   = pay_q;
  assign old_o       = old_q;
endmodule

// File: rtl/mbox_rmw_writer.sv
module mbox_rmw_writer #(
  parameter int unsigned       NUM_CORES = 4,
  parameter logic [11:0]       MAIL_OFF  = 12'h048,
  parameter logic [11:0]       ANY_OFF   = 12'h158,
  parameter logic [15:0]       MBOX_BASE = 16'h1000,
  localparam int unsigned      IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned      ADDR_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_is64_i,
  input  logic [11:0]       cmd_off_i,
  input  logic [63:0]       cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  mem_core_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i
);
  logic              dec_hit, dec_known;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] dec_addr;
  logic [3:0]        dec_keep, keep_q;
  logic [31:0]       dec_pay, pay_q, old_q;
  logic              idle;

  mbox_cmd_decode #(
    .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .MAIL_OFF(MAIL_OFF), .ANY_OFF(ANY_OFF), .MBOX_BASE(MBOX_BASE)
  ) u_dec (
    .off_i(cmd_off_i), .is64_i(cmd_is64_i), .data_i(cmd_data_i),
    .hit_o(dec_hit), .known_o(dec_known), .idx_o(dec_idx),
    .addr_o(dec_addr), .keep_o(dec_keep), .payload_o(dec_pay)
  );

  mbox_rmw_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(cmd_valid_i && idle),
    .hit_i(dec_hit), .known_i(dec_known), .idx_i(dec_idx),
    .addr_i(dec_addr), .keep_i(dec_keep), .payload_i(dec_pay),
    .idle_o(idle), .rsp_valid_o, .rsp_err_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_core_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .keep_o(keep_q), .payload_o(pay_q), .old_o(old_q)
  );

  mbox_byte_merge #(.BYTES(mbox_pkg::WORD_BYTES)) u_merge (
    .keep_i(keep_q), .old_i(old_q), .new_i(pay_q), .word_o(mem_wdata_o)
  );

  assign cmd_ready_o = idle;
endmodule

// File: rtl/mbox_rmw_writer_chk.sv
module mbox_rmw_writer_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned IDX_W     = 2,
  parameter logic [11:0] MAIL_OFF  = 12'h048,
  parameter logic [11:0] ANY_OFF   = 12'h158
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             cmd_is64_i,
  input logic [11:0]      cmd_off_i,
  input logic [9:0]       cmd_id_i,
  input logic [3:0]       cmd_keep_i,
  input logic             rsp_valid_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [15:0]      mem_addr_o,
  input logic [IDX_W-1:0] mem_core_o,
  input logic             mem_gnt_i
);
  logic acc_hit, acc_known;
  assign acc_hit   = cmd_valid_i && cmd_ready_o && cmd_is64_i &&
                     (cmd_off_i == MAIL_OFF || cmd_off_i == ANY_OFF);
  assign acc_known = 32'(cmd_id_i) < NUM_CORES;

  // R3
  unknown_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit && !acc_known |=> !mem_req_o && rsp_valid_o);
  // R7
  nokeep_direct_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit && acc_known && cmd_keep_i == 4'b0 |=> mem_req_o && mem_we_o);
  // R6
  keep_reads_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hit && acc_known && cmd_keep_i != 4'b0 |=> mem_req_o && !mem_we_o);
  // R9
  rsp_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  busy_while_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cmd_ready_o);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R8
  core_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> 32'(mem_core_o) < NUM_CORES);
endmodule

bind mbox_rmw_writer mbox_rmw_writer_chk #(
  .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .MAIL_OFF(MAIL_OFF), .ANY_OFF(ANY_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o), .cmd_is64_i(cmd_is64_i), .cmd_off_i(cmd_off_i),
  .cmd_id_i(cmd_data_i[25:16]), .cmd_keep_i(cmd_data_i[30:27]),
  .rsp_valid_o(rsp_valid_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_core_o(mem_core_o), .mem_gnt_i(mem_gnt_i)
);

// File: tb/mbox_rmw_writer_bench.sv
module mbox_rmw_writer_bench;
  localparam int NC = 4;
  localparam logic [11:0] MAIL = 12'h048;
  localparam logic [11:0] ANY  = 12'h158;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_is64 = 0;
  logic [11:0] cmd_off = '0;
  logic [63:0] cmd_data = '0;
  logic        cmd_ready, rsp_valid, rsp_err;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [1:0]  mem_core;
  logic [31:0] mem_wdata;
  logic        mem_gnt = 0, rv_q = 0;
  logic [31:0] rd_q = '0;

  int errors = 0, checks = 0, rd_cnt = 0, wr_cnt = 0;
  bit done = 0;
  logic [31:0] mem    [NC][1024];
  logic [31:0] refmem [NC][1024];

  always #2 clk = ~clk;

  mbox_rmw_writer u_mbox_rmw_writer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_is64_i(cmd_is64), .cmd_off_i(cmd_off), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_core_o(mem_core),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(rv_q),
    .mem_rdata_i(rd_q)
  );

  function automatic logic [31:0] pattern(int c, int w);
    return 32'(c * 32'h01010101) ^ 32'(w * 32'h9E3779B1) ^ 32'hA5C3_0F17;
  endfunction

  function automatic logic [31:0] merge_exp(logic [31:0] old, logic [63:0] d);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = d[27+b] ? old[8*b +: 8] : d[32+8*b +: 8];
    return r;
  endfunction

  function automatic int word_of(logic [11:0] off, logic [63:0] d);
    logic [15:0] a;
    a = (off == MAIL) ? 16'h1020 + 16'(d[4:2]) * 16'd4 : d[15:0];
    return int'(a[11:2]);
  endfunction

  // memory model with random grant
  always @(negedge clk) mem_gnt = ($urandom % 3) != 0;

  always @(posedge clk) begin
    rv_q <= 1'b0;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < 1024; w++) mem[c][w] <= pattern(c, w);
    end else if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_core][mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rv_q   <= 1'b1;
        rd_q   <= mem[mem_core][mem_addr[11:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // R10 monitor: ungranted request must persist unchanged
  logic        hold_pend = 0, hold_we = 0;
  logic [15:0] hold_addr = '0;
  always @(posedge clk) begin
    if (rst_n && hold_pend) begin
      checks++;
      if (mem_req !== 1'b1 || mem_addr !== hold_addr || mem_we !== hold_we) begin
        errors++;
        $display("FAIL R10 request held: req=%0b addr=%h we=%0b exp req=1 addr=%h we=%0b",
                 mem_req, mem_addr, mem_we, hold_addr, hold_we);
      end
    end
    hold_pend <= rst_n && mem_req && !mem_gnt;
    hold_addr <= mem_addr;
    hold_we   <= mem_we;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(logic [11:0] off, logic is64, logic [63:0] d, string tag);
    logic hit, known, err;
    int rd0, wr0, c, w;
    hit   = is64 && (off == MAIL || off == ANY);
    known = d[25:16] < NC;
    c = int'(d[17:16]);
    w = word_of(off, d);
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    cmd_valid = 1; cmd_off = off; cmd_is64 = is64; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    chk({tag, " R9 ready low after accept"}, 64'(cmd_ready), 64'(0));
    while (!rsp_valid) @(negedge clk);
    err = rsp_err;
    @(negedge clk);
    chk({tag, " R9 response one cycle"}, 64'(rsp_valid), 64'(0));
    chk({tag, " R3/R9 error flag"}, 64'(err), 64'(hit && !known));
    if (hit && known) begin
      refmem[c][w] = merge_exp(refmem[c][w], d);
      chk({tag, " R6/R7 read count"}, 64'(rd_cnt - rd0), 64'(d[30:27] != 0));
      chk({tag, " R6/R8 write count"}, 64'(wr_cnt - wr0), 64'(1));
      chk({tag, " R4/R5/R6/R8 target word"}, 64'(mem[c][w]), 64'(refmem[c][w]));
    end else begin
      chk({tag, " R1/R2/R3 no traffic"}, 64'((rd_cnt - rd0) + (wr_cnt - wr0)), 64'(0));
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] pay, logic [3:0] keep,
                                     logic [9:0] id, logic [15:0] lo);
    return {pay, 1'b0, keep, 1'b0, id, lo};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < 1024; w++) refmem[c][w] = pattern(c, w);
    repeat (3) @(negedge clk);
    chk("R9 reset ready", 64'(cmd_ready), 64'(1));
    chk("R9 reset rsp", 64'(rsp_valid), 64'(0));
    chk("R8 reset req", 64'(mem_req), 64'(0));
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_cmd(MAIL, 1, mk(32'hDEADBEEF, 4'b0000, 10'd1, 16'h000C), "R4 R7 mail slot3 nokeep");
    run_cmd(ANY,  1, mk(32'h11223344, 4'b1010, 10'd2, 16'h0234), "R5 R6 any mixed keep");
    run_cmd(MAIL, 1, mk(32'hFFFFFFFF, 4'b1111, 10'd3, 16'h001C), "R6 all keep");
    run_cmd(ANY,  1, mk(32'h00AA00BB, 4'b0001, 10'd0, 16'h0FFC), "R5 R6 keep byte0");
    run_cmd(MAIL, 1, mk(32'h12345678, 4'b0000, 10'd4, 16'h0000), "R3 id at limit");
    run_cmd(ANY,  1, mk(32'h12345678, 4'b0110, 10'h3FF, 16'h0100), "R3 id max");
    run_cmd(12'h050, 1, mk(32'h55555555, 4'b0000, 10'd1, 16'h0020), "R2 other offset");
    run_cmd(12'h158 ^ 12'h100, 1, mk(32'h55555555, 4'b0000, 10'd1, 16'h0020), "R2 near offset");
    run_cmd(MAIL, 0, mk(32'h66666666, 4'b0000, 10'd1, 16'h0004), "R1 narrow write");
    // R8: same word in core 2 only; core 1 copy must stay put
    run_cmd(MAIL, 1, mk(32'hCAFEF00D, 4'b0000, 10'd2, 16'h0008), "R8 core tag");
    chk("R8 neighbour core untouched", 64'(mem[1][word_of(MAIL, 64'h8)]),
        64'(refmem[1][word_of(MAIL, 64'h8)]));

    for (int i = 0; i < 300; i++) begin
      int k;
      logic [63:0] d;
      logic [11:0] off;
      logic is64;
      k = $urandom % 20;
      d = {$urandom, $urandom};
      d[25:16] = (k == 0) ? 10'($urandom % 1024) : 10'($urandom % NC);
      off  = (k == 1) ? 12'($urandom) : (k[0] ? MAIL : ANY);
      is64 = (k != 2);
      run_cmd(off, is64, d, "random R1-mix");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule